// File: doc/BRIEF.md
# Byte-Lane Little-Endian Data Memory

This block is a data store for a simple processor datapath. A requester presents a 32-bit byte address, 32 bits of write data, an enable and a 2-bit operation code. The code asks either for a full-word read or for a store of one byte, two bytes or four bytes. The storage is an array of 32-bit words. Each word is split into four byte lanes, and each lane has its own write enable. The least significant byte of a word lives at the lowest byte address.

Read data is combinational and comes from the word chosen by the address bits above the byte offset. Those bits wrap modulo the configured word count, so a small array repeats across the address space. Stores take effect at the rising clock edge. An access whose size does not match its address alignment raises an error flag in the same cycle and leaves the array untouched. When the enable is low the block does nothing. An option selects whether reset clears the array.

Top module: `dmem_ctrl`

## Requirements
- R1: With the clear-on-reset option set (the default), every word of the array reads as zero after reset.
- R2: The read data always shows the word at index addr[IDX_W+1:2], where IDX_W = log2(DEPTH). It is assembled little-endian, so the byte at the lowest address is bits 7:0.
- R3: Operation code 2'b01 with the enable high writes wdata[7:0] into the lane chosen by addr[1:0]. The other three lanes of that word keep their contents.
- R4: Operation code 2'b10 with addr[0]=0 writes wdata[15:0]. When addr[1]=0 it goes to lanes 1:0, and when addr[1]=1 it goes to lanes 3:2. The other lanes keep their contents.
- R5: Operation code 2'b11 with addr[1:0]=0 replaces the whole word with wdata.
- R6: With the enable low, no word changes and the error flag stays low, whatever the code and the address.
- R7: The error flag goes high in the same cycle as an enabled access with a bad alignment, and no lane is written. A bad alignment is code 2'b00 or 2'b11 with addr[1:0]≠0, or code 2'b10 with addr[0]=1. Byte stores never flag.
- R8: The layout is little-endian. A word store of 0x12345678 at byte address 1000 reads back with 0x78 in bits 7:0 (byte 1000) and 0x56 in bits 15:8 (byte 1001).
- R9: Addresses that differ only above bit IDX_W+1 select the same word.
- R10: A store becomes visible on the read data in the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores take effect on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Request valid |
| op | input | 2 | 00 word read, 01 byte store, 10 halfword store, 11 word store |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Store data, right-aligned for sub-word stores |
| rdata | output | DATA_W | Word at the addressed index, combinational |
| err | output | 1 | Misaligned enabled access in this cycle |

## Verification
The bench aims at each byte lane with byte stores and at both halfword positions. A design with a bad lane decode would corrupt a neighbouring byte, and a design with a bad byte order would swap bytes on read-back. Misaligned halfword and word stores, and misaligned reads, are issued against known contents. A design that still wrote on these would change bytes, and one that missed the flag would show err low. Addresses one array size apart and far above it are used to catch a wrong index slice. Stores with the enable low are driven with all codes to make sure nothing leaks through.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   typedef enum logic [1:0] {
      MOP_LOAD_W  = 2'b00,
      MOP_STORE_B = 2'b01,
      MOP_STORE_H = 2'b10,
      MOP_STORE_W = 2'b11
   } mem_op_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned LANES  = 4;

endpackage

// File: rtl/dmem_lane_ctl.sv
module dmem_lane_ctl
   import dmem_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              en,
   input  logic [1:0]        op,
   input  logic [1:0]        offs,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  lane_we,
   output logic [DATA_W-1:0] lane_data,
   output logic              misaligned
);

   mem_op_e kind;
   assign kind = mem_op_e'(op);

   always_comb begin
      lane_we    = '0;
      lane_data  = wdata;
      misaligned = 1'b0;
      unique case (kind)
         MOP_LOAD_W: begin
            misaligned = (offs != 2'b00);
         end
         MOP_STORE_B: begin
            lane_data = {LANES{wdata[BYTE_W-1:0]}};
            lane_we   = LANES'(1) << offs;
         end
         MOP_STORE_H: begin
            lane_data  = {2{wdata[2*BYTE_W-1:0]}};
            misaligned = offs[0];
            if (!offs[0]) begin
               lane_we = offs[1] ? 4'b1100 : 4'b0011;
            end
         end
         MOP_STORE_W: begin
            misaligned = (offs != 2'b00);
            if (offs == 2'b00) begin
               lane_we = '1;
            end
         end
         default: begin
            lane_we = '0;
         end
      endcase
      if (!en) begin
         lane_we    = '0;
         misaligned = 1'b0;
      end
   end

endmodule

// File: rtl/dmem_store.sv
module dmem_store
   import dmem_pkg::*;
#(
   parameter int unsigned DEPTH          = 64,
   parameter bit          CLEAR_ON_RESET = 1'b1,
   localparam int unsigned IDX_W         = $clog2(DEPTH),
   localparam int unsigned DATA_W        = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LANES-1:0]  lane_we,
   input  logic [DATA_W-1:0] lane_data,
   output logic [DATA_W-1:0] rd_word
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BYTE_W-1:0] bank [DEPTH];

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int w = 0; w < DEPTH; w++) begin
                  bank[w] <= '0;
               end
            end else if (lane_we[g]) begin
               bank[idx] <= lane_data[g*BYTE_W +: BYTE_W];
            end
         end
      end else begin : g_keep
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (lane_we[g]) begin
               bank[idx] <= lane_data[g*BYTE_W +: BYTE_W];
            end
         end
      end

      assign rd_word[g*BYTE_W +: BYTE_W] = bank[idx];
   end

endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
   import dmem_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned DEPTH          = 64,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned IDX_HI = IDX_W + 1;

   if (DATA_W != LANES * BYTE_W) begin : g_bad_width
      $error("dmem_ctrl: DATA_W must equal four byte lanes");
   end
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("dmem_ctrl: DEPTH must be a power of two, at least 2");
   end
   if (ADDR_W <= IDX_HI + 1) begin : g_bad_addr
      $error("dmem_ctrl: ADDR_W too narrow for DEPTH");
   end

   logic [LANES-1:0]  lane_we;
   logic [DATA_W-1:0] lane_data;
   logic [IDX_W-1:0]  idx;
   logic              unused_hi;

   assign idx       = addr[IDX_HI:2];
   assign unused_hi = ^addr[ADDR_W-1:IDX_HI+1];

   dmem_lane_ctl #(.DATA_W(DATA_W)) u_lane (
      .en        (en),
      .op        (op),
      .offs      (addr[1:0]),
      .wdata     (wdata),
      .lane_we   (lane_we),
      .lane_data (lane_data),
      .misaligned(err)
   );

   dmem_store #(.DEPTH(DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (idx),
      .lane_we  (lane_we),
      .lane_data(lane_data),
      .rd_word  (rdata)
   );

endmodule

// File: rtl/dmem_ctrl_chk.sv
module dmem_ctrl_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [1:0]        op,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              err,
   input logic [3:0]        lane_we
);

   // R3
   byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == 2'b01) |-> ($countones(lane_we) == 1 && !err));

   // R6
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (lane_we == 4'b0000 && !err));

   // R7
   err_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (lane_we == 4'b0000));

   // R2
   read_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == 2'b00) |-> (lane_we == 4'b0000));

   // R4
   half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == 2'b10 && !addr[0]) |->
         (lane_we == (addr[1] ? 4'b1100 : 4'b0011)));

   // R10
   word_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == 2'b11 && addr[1:0] == 2'b00) |=>
         ((addr != $past(addr)) || (rdata == $past(wdata))));

endmodule

bind dmem_ctrl dmem_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .op     (op),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .err    (err),
   .lane_we(lane_we)
);

// File: tb/tb_dmem_ctrl.sv
module tb_dmem_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int NBYTES     = DEPTH * 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] model [NBYTES];

   always #(CLK_PERIOD/2) clk = ~clk;

   dmem_ctrl #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .op(op),
      .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
   );

   function automatic logic [31:0] model_word(logic [31:0] a);
      int b;
      b = ((a >> 2) % DEPTH) * 4;
      return {model[b+3], model[b+2], model[b+1], model[b]};
   endfunction

   function automatic logic model_err(logic e, logic [1:0] o, logic [31:0] a);
      if (!e) return 1'b0;
      case (o)
         2'b00, 2'b11: return a[1:0] != 2'b00;
         2'b10:        return a[0];
         default:      return 1'b0;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // drive one request, check outputs before the edge, update the model
   task automatic do_op(logic e, logic [1:0] o, logic [31:0] a,
                        logic [31:0] d, string tag);
      int b;
      @(negedge clk);
      en = e; op = o; addr = a; wdata = d;
      #1;
      check({tag, " rdata"}, rdata, model_word(a));
      check({tag, " err"}, {31'b0, err}, {31'b0, model_err(e, o, a)});
      if (e && !model_err(e, o, a)) begin
         b = (a % NBYTES);
         case (o)
            2'b01: model[b] = d[7:0];
            2'b10: begin model[b] = d[7:0]; model[b+1] = d[15:8]; end
            2'b11: begin
               model[b] = d[7:0];    model[b+1] = d[15:8];
               model[b+2] = d[23:16]; model[b+3] = d[31:24];
            end
            default: ;
         endcase
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      summary();
   end

   initial begin
      for (int i = 0; i < NBYTES; i++) model[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset clears every word
      for (int w = 0; w < DEPTH; w++) do_op(1'b0, 2'b00, w * 4, 32'h0, "R1");

      // R8 little-endian placement: 1000 maps to word 10
      do_op(1'b1, 2'b11, 32'd1000, 32'h12345678, "R5");
      do_op(1'b1, 2'b00, 32'd1000, 32'h0, "R10");
      check("R8 byte1000", {24'b0, rdata[7:0]}, 32'h78);
      check("R8 byte1001", {24'b0, rdata[15:8]}, 32'h56);
      do_op(1'b1, 2'b11, 32'd8, 32'd5, "R5");
      do_op(1'b1, 2'b00, 32'd8, 32'h0, "R8");
      check("R8 byte8", {24'b0, rdata[7:0]}, 32'h05);

      // R3 each byte lane
      for (int l = 0; l < 4; l++) do_op(1'b1, 2'b01, 32'd16 + l, 32'hFFFF_FF00 | (8'hA0 + l), "R3");
      do_op(1'b1, 2'b00, 32'd16, 32'h0, "R3");
      check("R3 lanes", rdata, 32'hA3A2A1A0);
      do_op(1'b1, 2'b01, 32'd18, 32'h0000_0055, "R3");
      do_op(1'b1, 2'b00, 32'd16, 32'h0, "R3");
      check("R3 one lane", rdata, 32'hA355A1A0);

      // R4 both halves
      do_op(1'b1, 2'b10, 32'd20, 32'hDEAD_BEEF, "R4");
      do_op(1'b1, 2'b10, 32'd22, 32'h1111_CAFE, "R4");
      do_op(1'b1, 2'b00, 32'd20, 32'h0, "R4");
      check("R4 halves", rdata, 32'hCAFEBEEF);

      // R7 misaligned accesses leave memory alone
      do_op(1'b1, 2'b10, 32'd21, 32'h0000_0000, "R7");
      do_op(1'b1, 2'b10, 32'd23, 32'h0000_0000, "R7");
      do_op(1'b1, 2'b11, 32'd22, 32'h0000_0000, "R7");
      do_op(1'b1, 2'b11, 32'd17, 32'h0000_0000, "R7");
      do_op(1'b1, 2'b00, 32'd19, 32'h0, "R7");
      do_op(1'b1, 2'b00, 32'd20, 32'h0, "R7");
      check("R7 untouched", rdata, 32'hCAFEBEEF);

      // R6 enable low blocks all codes
      for (int o = 0; o < 4; o++) do_op(1'b0, o[1:0], 32'd20, 32'h0, "R6");
      do_op(1'b1, 2'b00, 32'd20, 32'h0, "R6");
      check("R6 untouched", rdata, 32'hCAFEBEEF);

      // R9 aliasing modulo depth
      do_op(1'b1, 2'b11, 32'd4 + NBYTES, 32'h0BAD_F00D, "R9");
      do_op(1'b1, 2'b00, 32'd4, 32'h0, "R9");
      check("R9 alias", rdata, 32'h0BADF00D);
      do_op(1'b1, 2'b01, 32'hFFFF_FFC5, 32'h0000_0077, "R9");
      do_op(1'b1, 2'b00, 32'd4, 32'h0, "R9");

      // R2 mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         do_op(($urandom % 5) != 0, 2'($urandom), $urandom, $urandom, "R2");
      end

      summary();
   end

endmodule